// File: doc/BRIEF.md
# UART Receive Word Packer

This block takes the byte stream coming out of a UART receiver's deserializer and assembles it into 32-bit words for a bus reader. The earliest byte of each group lands in the lowest byte lane. A word is complete after four bytes, and it is then pushed into a small receive FIFO. The head of that FIFO is always visible on `rx_word`, and one pulse on `rd_pop` removes it.

A 16-bit status word reports several things. It shows whether a whole word is waiting in the FIFO. It gives a live count of the bytes held in the partial packing buffer. It also carries two sticky flags: one for lost data and one for a stale flush event. Software can drain a partial word with a force-stale command. That command pushes whatever is in the packing buffer into the FIFO, with the unused upper lanes set to zero. After a flush, the force-stale path stays disarmed until software re-arms reception. Other commands clear the sticky flags or reset the whole receive path.

Top module: `rx_word_packer`

## Requirements
- R1: Four accepted bytes form one FIFO word: the first byte goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R2: Status bit 0 is 1 exactly when the FIFO holds at least one word. `rx_word` shows the oldest word. A `rd_pop` pulse removes it, and bit 0 reflects the new occupancy in the cycle after the pop.
- R3: Status bits [9:7] give the number of bytes in the packing buffer, from 0 to 3. The count returns to 0 when the fourth byte completes a word.
- R4: A command with value 4 in field [11:8], issued while the receiver is armed and the FIFO is not full, does three things. It pushes the partial buffer as a word with the unfilled upper bytes at zero (nothing is pushed if the buffer is empty). It zeroes the count. It sets the stale flag in status bit 6.
- R5: A command with value 8 in field [7:4] clears status bit 6.
- R6: A byte that would complete a word while the FIFO is full is discarded, and status bit 4 (overrun) is set. The three buffered bytes are kept.
- R7: A command with value 3 in field [7:4] clears status bit 4.
- R8: After a force-stale, further force-stale commands are ignored until `rx_rearm` is pulsed.
- R9: If a byte arrives in the same cycle as a force-stale command, the byte is accepted and the command is ignored. The receiver stays armed.
- R10: A command with value 1 in field [7:4] empties the packing buffer and the FIFO. Status bit 0 and bits [9:7] then read zero, and later bytes start again at bits [7:0].
- R11: After reset the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| cmd_wr | input | 1 | Command write strobe |
| cmd_val | input | 8 | Command bits [11:4]: field [7:4] and field [11:8] |
| rx_rearm | input | 1 | Pulse to re-arm reception after a stale flush |
| rd_pop | input | 1 | Remove the FIFO head word |
| rx_word | output | 32 | FIFO head word |
| rx_status | output | 16 | Status: bit 0 ready, bit 4 overrun, bit 6 stale, bits [9:7] byte count |

## Verification
The assertions check properties that must hold on every cycle:
- the byte count never exceeds three;
- the FIFO is never written while full;
- an overrun event always sets the overrun flag and leaves the count unchanged;
- a stale event always sets the stale flag and zeroes the count;
- a receiver reset always leaves the ready bit and the count at zero.

Other behaviours can only be shown by the bench's scenarios. These are the lane order of the packed words, the zero fill of flushed partial words, the disarm and re-arm sequence, the priority of a byte over a force-stale command in the same cycle, and the order of words across a full FIFO. The bench's scoreboard checks each of these against words it predicts itself.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int WORD_W   = BYTE_W * LANES;
  localparam int CNT_W    = 3;
  localparam int STATUS_W = 16;

  // command codes in the low field [7:4]
  localparam logic [3:0] CMD_RX_RESET    = 4'h1;
  localparam logic [3:0] CMD_CLR_OVR     = 4'h3;
  localparam logic [3:0] CMD_CLR_STALE   = 4'h8;
  // command code in the high field [11:8]
  localparam logic [3:0] CMD_FORCE_STALE = 4'h4;

  function automatic logic [3:0] low_field(logic [11:4] c);
    return c[7:4];
  endfunction

  function automatic logic [3:0] high_field(logic [11:4] c);
    return c[11:8];
  endfunction

  // place byte b into lane idx of word w
  function automatic logic [WORD_W-1:0] put_lane(logic [WORD_W-1:0] w,
                                                 logic [1:0] idx,
                                                 logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[idx*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  function automatic logic [STATUS_W-1:0] make_status(logic rdy, logic ovr,
                                                      logic stl,
                                                      logic [CNT_W-1:0] c);
    logic [STATUS_W-1:0] s;
    s      = '0;
    s[0]   = rdy;
    s[4]   = ovr;
    s[6]   = stl;
    s[9:7] = c;
    return s;
  endfunction
endpackage

// File: rtl/rxp_pack_buf.sv
module rxp_pack_buf
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] buf_q,
  output logic [CNT_W-1:0]  cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (clr || take) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      buf_q <= put_lane(buf_q, cnt_q[1:0], din);
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxp_word_fifo.sv
module rxp_word_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxp_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_byte_valid,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                cmd_wr,
  input  logic [11:4]         cmd_val,
  input  logic                rx_rearm,
  input  logic                rd_pop,
  output logic [WORD_W-1:0]   rx_word,
  output logic [STATUS_W-1:0] rx_status
);
  logic [WORD_W-1:0] buf_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              fifo_full, fifo_empty;
  logic              ovr_q, stale_q, armed_q;

  // named events, also observed by the checker
  logic              w_rx_reset, w_clr_ovr, w_clr_stale, w_force;
  logic              w_last_lane, w_accept, w_complete, w_load;
  logic              w_ovr_evt, w_stale_evt, w_flush, w_push, w_pop;
  logic [WORD_W-1:0] w_push_word;

  assign w_rx_reset  = cmd_wr && (low_field(cmd_val) == CMD_RX_RESET);
  assign w_clr_ovr   = cmd_wr && (low_field(cmd_val) == CMD_CLR_OVR);
  assign w_clr_stale = cmd_wr && (low_field(cmd_val) == CMD_CLR_STALE);
  assign w_force     = cmd_wr && (high_field(cmd_val) == CMD_FORCE_STALE);

  assign w_last_lane = (cnt_w == CNT_W'(LANES - 1));
  assign w_ovr_evt   = rx_byte_valid && !w_rx_reset && w_last_lane && fifo_full;
  assign w_accept    = rx_byte_valid && !w_rx_reset && !w_ovr_evt;
  assign w_complete  = w_accept && w_last_lane;
  assign w_load      = w_accept && !w_last_lane;

  assign w_stale_evt = w_force && armed_q && !rx_byte_valid && !w_rx_reset && !fifo_full;
  assign w_flush     = w_stale_evt && (cnt_w != '0);

  assign w_push      = w_complete || w_flush;
  assign w_push_word = w_complete ? put_lane(buf_w, 2'(LANES - 1), rx_byte) : buf_w;
  assign w_pop       = rd_pop && !fifo_empty && !w_rx_reset;

  rxp_pack_buf u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (w_rx_reset),
    .load  (w_load),
    .take  (w_push),
    .din   (rx_byte),
    .buf_q (buf_w),
    .cnt_q (cnt_w)
  );

  rxp_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (w_rx_reset),
    .push  (w_push),
    .wdata (w_push_word),
    .pop   (w_pop),
    .rdata (rx_word),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      stale_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (w_ovr_evt)        ovr_q <= 1'b1;
      else if (w_clr_ovr)   ovr_q <= 1'b0;
      if (w_stale_evt)      stale_q <= 1'b1;
      else if (w_clr_stale) stale_q <= 1'b0;
      if (w_stale_evt)      armed_q <= 1'b0;
      else if (rx_rearm)    armed_q <= 1'b1;
    end
  end

  assign rx_status = make_status(!fifo_empty, ovr_q, stale_q, cnt_w);
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status,
  input logic        push,
  input logic        full,
  input logic        ovr_evt,
  input logic        stale_evt,
  input logic        rx_reset
);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[9:7] <= 3'd3);

  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_ovr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status[4]);

  p_ovr_keeps_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(status[9:7]));

  p_stale_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stale_evt |=> (status[6] && status[9:7] == 3'd0));

  p_ready_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> status[0]);

  p_rx_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!status[0] && status[9:7] == 3'd0));
endmodule

bind rx_word_packer rxp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (rx_status),
  .push      (w_push),
  .full      (fifo_full),
  .ovr_evt   (w_ovr_evt),
  .stale_evt (w_stale_evt),
  .rx_reset  (w_rx_reset)
);

// File: tb/rx_word_packer_bench.sv
module rx_word_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        cmd_wr = 1'b0;
  logic [11:4] cmd_val = '0;
  logic        rx_rearm = 1'b0;
  logic        rd_pop = 1'b0;
  logic [31:0] rx_word;
  logic [15:0] rx_status;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_word_packer u_rx_word_packer (
    .clk(clk), .rst_n(rst_n), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .cmd_wr(cmd_wr), .cmd_val(cmd_val), .rx_rearm(rx_rearm), .rd_pop(rd_pop),
    .rx_word(rx_word), .rx_status(rx_status)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops head words and compares with the scoreboard
  always @(negedge clk) begin
    if (mon_en && rx_status[0] && rst_n) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", rx_word, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R1 word content", rx_word, e);
      end
      rd_pop = 1'b1;
    end else rd_pop = 1'b0;
  end

  task automatic send_byte(logic [7:0] b);
    rx_byte_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  // driver: four bytes and the word the scoreboard expects
  task automatic send_word(logic [7:0] b0, b1, b2, b3);
    send_byte(b0); send_byte(b1); send_byte(b2); send_byte(b3);
    exp_q.push_back({b3, b2, b1, b0});
  endtask

  task automatic do_cmd(logic [11:4] v);
    cmd_wr = 1'b1; cmd_val = v;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_val = '0;
  endtask

  task automatic rearm();
    rx_rearm = 1'b1;
    @(negedge clk);
    rx_rearm = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    mon_en = 1'b1;
    while (exp_q.size() != 0 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk); @(negedge clk);
    mon_en = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    chk(rx_status[0] == 1'b0, "R2 ready low after last pop", 32'(rx_status[0]), 32'd0);
  endtask

  function automatic logic [2:0] cnt_f();
    return rx_status[9:7];
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rx_status == 16'h0, "R11 reset status", 32'(rx_status), 32'h0);

    // R1, R3: lane order and live count
    send_byte(8'h11);
    chk(cnt_f() == 3'd1, "R3 count after 1", 32'(cnt_f()), 32'd1);
    send_byte(8'h22);
    send_byte(8'h33);
    chk(cnt_f() == 3'd3, "R3 count after 3", 32'(cnt_f()), 32'd3);
    send_byte(8'h44);
    exp_q.push_back(32'h44332211);
    chk(cnt_f() == 3'd0, "R3 count back to 0", 32'(cnt_f()), 32'd0);
    chk(rx_status[0] == 1'b1, "R2 ready with a word", 32'(rx_status[0]), 32'd1);
    chk(rx_word == 32'h44332211, "R1 lane order", rx_word, 32'h44332211);
    send_word(8'hDE, 8'hAD, 8'hBE, 8'hEF);
    drain();

    // R4, R5: partial flush with zero fill
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    do_cmd(8'h40);
    exp_q.push_back(32'h00A3A2A1);
    chk(cnt_f() == 3'd0, "R4 count zero after flush", 32'(cnt_f()), 32'd0);
    chk(rx_status[6] == 1'b1, "R4 stale flag set", 32'(rx_status[6]), 32'd1);
    chk(rx_word == 32'h00A3A2A1, "R4 zero-filled word", rx_word, 32'h00A3A2A1);
    drain();
    do_cmd(8'h08);
    chk(rx_status[6] == 1'b0, "R5 stale flag cleared", 32'(rx_status[6]), 32'd0);

    // R8: disarmed until re-arm
    send_byte(8'hB1);
    do_cmd(8'h40);
    chk(cnt_f() == 3'd1 && !rx_status[0] && !rx_status[6], "R8 force ignored while disarmed",
        32'(rx_status), 32'h0080);
    rearm();
    do_cmd(8'h40);
    exp_q.push_back(32'h000000B1);
    chk(cnt_f() == 3'd0 && rx_status[6], "R8 flush after re-arm", 32'(rx_status), 32'h0041);
    drain();
    do_cmd(8'h08);

    // R9: byte wins over force-stale in the same cycle
    rearm();
    rx_byte_valid = 1'b1; rx_byte = 8'hC1; cmd_wr = 1'b1; cmd_val = 8'h40;
    @(negedge clk);
    rx_byte_valid = 1'b0; cmd_wr = 1'b0; cmd_val = '0;
    chk(cnt_f() == 3'd1 && !rx_status[6] && !rx_status[0], "R9 byte taken, command ignored",
        32'(rx_status), 32'h0080);
    do_cmd(8'h40);
    exp_q.push_back(32'h000000C1);
    chk(rx_status[6] == 1'b1, "R9 still armed afterwards", 32'(rx_status[6]), 32'd1);
    drain();
    do_cmd(8'h08);
    rearm();

    // R6, R7: overrun with full FIFO
    for (int i = 0; i < 4; i++)
      send_word(8'(16*i), 8'(16*i+1), 8'(16*i+2), 8'(16*i+3));
    send_byte(8'hE1); send_byte(8'hE2); send_byte(8'hE3);
    send_byte(8'hE4);
    chk(rx_status[4] == 1'b1, "R6 overrun flag", 32'(rx_status[4]), 32'd1);
    chk(cnt_f() == 3'd3, "R6 buffer kept", 32'(cnt_f()), 32'd3);
    do_cmd(8'h03);
    chk(rx_status[4] == 1'b0, "R7 overrun cleared", 32'(rx_status[4]), 32'd0);
    drain();
    send_byte(8'hE5);
    exp_q.push_back(32'hE5E3E2E1);
    drain();

    // R10: receiver reset
    send_word(8'h01, 8'h02, 8'h03, 8'h04);
    send_byte(8'h05); send_byte(8'h06);
    do_cmd(8'h01);
    exp_q.delete();
    chk(rx_status[0] == 1'b0 && cnt_f() == 3'd0, "R10 path emptied", 32'(rx_status), 32'h0);
    send_word(8'h71, 8'h72, 8'h73, 8'h74);
    chk(rx_word == 32'h74737271, "R10 restart at lane 0", rx_word, 32'h74737271);
    drain();

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule